// File: doc/BRIEF.md
# Nine-Valued Set/Reset Latch Bank

This block holds a bank of single-bit storage elements in which every bit, and every control, is carried as a four-bit code for one of nine logic values: uninitialised, unknown, strong zero and one, high impedance, weak unknown, weak zero and one, and don't-care. Synthesized logic can therefore carry "not yet initialised" and "unknown" through a design on purpose, instead of depending on how a simulator treats X. The stored result is always one of four strong values: U, X, 0 or 1.

Each rising clock edge is one evaluation step. The step reads the set, reset and enable codes and updates every bit of the bank. Set takes precedence over reset. An uncertain control spreads as U or X. When the result is ambiguous, a bit keeps its value only if that value would be the same whichever way the uncertain control resolved. A parameter chooses whether set and reset are asserted by a 1 or by a 0.

Top module: `nvl_latch_bank`

## Requirements
- R1: Input codes are 0=U, 1=X, 2='0', 3='1', 4=Z, 5=W, 6=L, 7=H, 8='-'. L counts as 0 and H as 1. Z, W, '-' and the unused codes 9 to 15 count as X. Each output nibble is only ever 0 (U), 1 (X), 2 ('0') or 3 ('1').
- R2: While rst_n is low, every output nibble is U (code 0), with no clock edge needed.
- R3: If set is U, the bit becomes U whatever the other inputs are.
- R4: If set is asserted (and not U), the bit becomes 1, even when reset is asserted or U.
- R5: If set is deasserted or X and reset is U, the bit becomes U.
- R6: If reset is asserted, the bit becomes 0 when set is deasserted and X when set is X.
- R7: If set and reset are each either deasserted or X, an enable of U makes the bit U.
- R8: If set and reset are both deasserted, an enable of 1 loads each bit with its classified data code, and an enable of 0 holds the stored value.
- R9: If set and reset are both deasserted and enable is X, each bit holds when its classified data equals the stored value, and otherwise becomes X.
- R10: If set is X and reset is deasserted, a bit holds when it stores 1 and otherwise becomes X. If reset is X and set is deasserted, a bit holds when it stores 0 and otherwise becomes X. If both are X, the bit becomes X. These rules apply when enable is not U.
- R11: With ACTIVE_LOW=1, a 0 (or L) on set or reset asserts it and a 1 (or H) deasserts it. Enable and data keep their normal sense.
- R12: The output changes only at a rising clock edge, one edge after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock; each rising edge is one step |
| rst_n | input | 1 | Asynchronous active-low power-up clear to U |
| en_code | input | 4 | Enable, as a nine-valued code |
| set_code | input | 4 | Set, as a nine-valued code (polarity set by ACTIVE_LOW) |
| clr_code | input | 4 | Reset, as a nine-valued code (polarity set by ACTIVE_LOW) |
| din | input | 4*WIDTH | Data codes, one nibble per bit |
| dout | output | 4*WIDTH | Stored values, one strong code per nibble |

## Verification
The assertions in each bit cell take for granted that the control mode and data code do not change inside a clock period and that rst_n stays high across each observed step. A reset, if one comes, simply disables them. The bench drives every input at the falling edge and leaves it unchanged through the following rising edge. It runs every one of the sixteen four-bit values on enable, set and reset for each polarity, so no control is ever given an undefined simulator value. Before each combination, a load step places U, X, 0 and 1 in the bank, so that each hold-or-X rule meets every stored value.

// File: rtl/nvl_pkg.sv
package nvl_pkg;

  localparam int CODE_W = 4;

  // Strong four-valued class; the numbering matches the output code.
  typedef enum logic [1:0] {
    NV_U = 2'd0,
    NV_X = 2'd1,
    NV_0 = 2'd2,
    NV_1 = 2'd3
  } nv_t;

  // Per-step action chosen from the control inputs.
  typedef enum logic [3:0] {
    M_U     = 4'd0,
    M_ONE   = 4'd1,
    M_ZERO  = 4'd2,
    M_X     = 4'd3,
    M_KEEP1 = 4'd4,
    M_KEEP0 = 4'd5,
    M_LOAD  = 4'd6,
    M_HOLD  = 4'd7,
    M_MERGE = 4'd8
  } mode_t;

  // Nine-value code to strong class; codes 9..15 are read as unknown.
  function automatic nv_t nv_class(input logic [CODE_W-1:0] c);
    nv_t v;
    case (c)
      4'd0:       v = NV_U;
      4'd2, 4'd6: v = NV_0;
      4'd3, 4'd7: v = NV_1;
      default:    v = NV_X;
    endcase
    return v;
  endfunction

  // Fold control polarity so that NV_1 always means "asserted".
  function automatic nv_t nv_polar(input nv_t v, input logic low);
    nv_t r;
    r = v;
    if (low && v == NV_0) r = NV_1;
    if (low && v == NV_1) r = NV_0;
    return r;
  endfunction

  // Priority decode: set, then reset, then enable.
  function automatic mode_t nv_decode(input nv_t s, input nv_t r, input nv_t e);
    mode_t m;
    if (s == NV_U)                    m = M_U;
    else if (s == NV_1)               m = M_ONE;
    else if (r == NV_U)               m = M_U;
    else if (r == NV_1)               m = (s == NV_0) ? M_ZERO : M_X;
    else if (e == NV_U)               m = M_U;
    else if (s == NV_X && r == NV_X)  m = M_X;
    else if (s == NV_X)               m = M_KEEP1;
    else if (r == NV_X)               m = M_KEEP0;
    else if (e == NV_1)               m = M_LOAD;
    else if (e == NV_0)               m = M_HOLD;
    else                              m = M_MERGE;
    return m;
  endfunction

  // Next stored class of one bit.
  function automatic nv_t nv_next(input mode_t m, input nv_t q, input nv_t d);
    nv_t n;
    case (m)
      M_U:     n = NV_U;
      M_ONE:   n = NV_1;
      M_ZERO:  n = NV_0;
      M_KEEP1: n = (q == NV_1) ? q : NV_X;
      M_KEEP0: n = (q == NV_0) ? q : NV_X;
      M_LOAD:  n = d;
      M_HOLD:  n = q;
      M_MERGE: n = (d == q) ? q : NV_X;
      default: n = NV_X;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/nvl_classify.sv
module nvl_classify
  import nvl_pkg::*;
#(
  parameter bit POLAR      = 1'b0,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [CODE_W-1:0] code_i,
  output nv_t               cls_o
);

  nv_t raw_cls;

  assign raw_cls = nv_class(code_i);

  generate
    if (POLAR) begin : g_polar
      assign cls_o = nv_polar(raw_cls, ACTIVE_LOW);
    end else begin : g_plain
      assign cls_o = raw_cls;
    end
  endgenerate

endmodule

// File: rtl/nvl_ctrl_decode.sv
module nvl_ctrl_decode
  import nvl_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [CODE_W-1:0] en_code_i,
  input  logic [CODE_W-1:0] set_code_i,
  input  logic [CODE_W-1:0] clr_code_i,
  output mode_t             mode_o
);

  nv_t en_cls;
  nv_t set_cls;
  nv_t clr_cls;

  nvl_classify #(.POLAR(1'b0), .ACTIVE_LOW(1'b0)) u_en (
    .code_i (en_code_i),
    .cls_o  (en_cls)
  );

  nvl_classify #(.POLAR(1'b1), .ACTIVE_LOW(ACTIVE_LOW)) u_set (
    .code_i (set_code_i),
    .cls_o  (set_cls)
  );

  nvl_classify #(.POLAR(1'b1), .ACTIVE_LOW(ACTIVE_LOW)) u_clr (
    .code_i (clr_code_i),
    .cls_o  (clr_cls)
  );

  assign mode_o = nv_decode(set_cls, clr_cls, en_cls);

endmodule

// File: rtl/nvl_bit_cell.sv
module nvl_bit_cell
  import nvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode_i,
  input  logic [CODE_W-1:0] din_i,
  output logic [CODE_W-1:0] dout_o
);

  nv_t d_cls;
  nv_t q;
  nv_t q_nxt;

  nvl_classify #(.POLAR(1'b0), .ACTIVE_LOW(1'b0)) u_dcls (
    .code_i (din_i),
    .cls_o  (d_cls)
  );

  assign q_nxt = nv_next(mode_i, q, d_cls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= NV_U;
    else        q <= q_nxt;
  end

  assign dout_o = {{(CODE_W-2){1'b0}}, q};

  AST_UNINIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_U) |=> (q == NV_U));                          // R3

  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_ONE) |=> (q == NV_1));                        // R4

  AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_ZERO) |=> (q == NV_0));                       // R6

  AST_LOAD_TRACKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_LOAD) |=> (q == $past(d_cls)));               // R8

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_HOLD) |=> $stable(q));                        // R8

  AST_MERGE_NO_ZERO_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_MERGE) |=> (q == $past(q) || q == NV_X));     // R9

endmodule

// File: rtl/nvl_latch_bank.sv
module nvl_latch_bank
  import nvl_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CODE_W-1:0]          en_code,
  input  logic [CODE_W-1:0]          set_code,
  input  logic [CODE_W-1:0]          clr_code,
  input  logic [WIDTH*CODE_W-1:0]    din,
  output logic [WIDTH*CODE_W-1:0]    dout
);

  localparam int BUS_W = WIDTH * CODE_W;

  mode_t step_mode;

  nvl_ctrl_decode #(.ACTIVE_LOW(ACTIVE_LOW)) u_dec (
    .en_code_i  (en_code),
    .set_code_i (set_code),
    .clr_code_i (clr_code),
    .mode_o     (step_mode)
  );

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      nvl_bit_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (step_mode),
        .din_i  (din[b*CODE_W +: CODE_W]),
        .dout_o (dout[b*CODE_W +: CODE_W])
      );
    end
  endgenerate

  AST_BUS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($bits(dout) == BUS_W) |-> !$isunknown(dout));             // R1

endmodule

// File: tb/sim_nvl_latch_bank.sv
`timescale 1ns/1ps
module sim_nvl_latch_bank;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0][3:0]   en_c;
  logic [1:0][3:0]   set_c;
  logic [1:0][3:0]   clr_c;
  logic [1:0][W*4-1:0] din_c;
  logic [W*4-1:0]    dout0;
  logic [W*4-1:0]    dout1;

  int checks = 0;
  int failures = 0;
  int mdl [2][W];

  always #4 clk = ~clk;

  nvl_latch_bank #(.WIDTH(W), .ACTIVE_LOW(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .en_code(en_c[0]), .set_code(set_c[0]),
    .clr_code(clr_c[0]), .din(din_c[0]), .dout(dout0));

  nvl_latch_bank #(.WIDTH(W), .ACTIVE_LOW(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .en_code(en_c[1]), .set_code(set_c[1]),
    .clr_code(clr_c[1]), .din(din_c[1]), .dout(dout1));

  // R1: class numbers U=0, X=1, zero=2, one=3
  function automatic int cls(input int code);
    if (code == 0) return 0;
    if (code == 2 || code == 6) return 2;
    if (code == 3 || code == 7) return 3;
    return 1;
  endfunction

  // R11: low polarity swaps zero and one
  function automatic int pol(input int v, input int low);
    if (low != 0 && v >= 2) return v ^ 1;
    return v;
  endfunction

  // Group of the [reset, set] pair: 1 U, 2 set, 3 clear, 6 clear+X,
  // 4 both X, 5 set X only, 7 reset X only, 8 both quiet.
  function automatic int grp(input int s, input int r);
    if (s == 0) return 1;
    if (s == 3) return 2;
    if (r == 0) return 1;
    if (r == 3) return (s == 2) ? 3 : 6;
    if (s == 1) return (r == 1) ? 4 : 5;
    return (r == 1) ? 7 : 8;
  endfunction

  function automatic int ref_bit(input int g, input int e, input int q, input int d);
    if (g == 1) return 0;
    if (g == 2) return 3;
    if (g == 3) return 2;
    if (g == 6) return 1;
    if (e == 0) return 0;
    if (g == 4) return 1;
    if (g == 5) return (q == 3) ? q : 1;
    if (g == 7) return (q == 2) ? q : 1;
    if (e == 3) return d;
    if (e == 2) return q;
    return (d == q) ? q : 1;
  endfunction

  function automatic string tag_of(input int g, input int s, input int e);
    if (g == 1) return (s == 0) ? "R3" : "R5";
    if (g == 2) return "R4";
    if (g == 3 || g == 6) return "R6";
    if (e == 0) return "R7";
    if (g == 4 || g == 5 || g == 7) return "R10";
    if (e == 1) return "R9";
    return "R8";
  endfunction

  function automatic logic [W*4-1:0] expect_vec(input int p);
    logic [W*4-1:0] v;
    for (int b = 0; b < W; b++) v[b*4 +: 4] = 4'(mdl[p][b]);
    return v;
  endfunction

  task automatic check_out(input int p, input string tag);
    logic [W*4-1:0] act;
    logic [W*4-1:0] exp;
    act = (p == 0) ? dout0 : dout1;
    exp = expect_vec(p);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s pol=%0d actual=%h expected=%h", tag, p, act, exp);
    end
  endtask

  task automatic apply(input int p, input int e, input int s, input int r,
                       input logic [W*4-1:0] d);
    int g;
    int ec;
    string tag;
    en_c[p] = 4'(e); set_c[p] = 4'(s); clr_c[p] = 4'(r); din_c[p] = d;
    #1;
    check_out(p, "R12");
    ec = cls(e);
    g = grp(pol(cls(s), p), pol(cls(r), p));
    tag = tag_of(g, pol(cls(s), p), ec);
    if (p == 1) tag = {"R11/", tag};
    @(posedge clk);
    for (int b = 0; b < W; b++)
      mdl[p][b] = ref_bit(g, ec, mdl[p][b], cls(int'(d[b*4 +: 4])));
    @(negedge clk);
    check_out(p, tag);
  endtask

  initial begin
    #(8.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W*4-1:0] pre;
    logic [W*4-1:0] dat;
    int quiet;
    for (int p = 0; p < 2; p++) begin
      en_c[p] = 4'd2; set_c[p] = (p == 0) ? 4'd2 : 4'd3;
      clr_c[p] = set_c[p]; din_c[p] = '0;
      for (int b = 0; b < W; b++) mdl[p][b] = 0;
    end
    repeat (3) @(negedge clk);
    check_out(0, "R2");
    check_out(1, "R11/R2");
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int idx = 0; idx < 4096; idx++) begin
        quiet = (p == 0) ? ((idx % 2) ? 6 : 2) : ((idx % 2) ? 7 : 3);
        for (int b = 0; b < W; b++) begin
          pre[b*4 +: 4] = 4'((idx + b) % 4);
          dat[b*4 +: 4] = 4'((idx * 7 + b * 5 + p) % 16);
        end
        apply(p, 3, quiet, quiet, pre);   // R1 R8 preset load
        apply(p, idx / 256, (idx / 16) % 16, idx % 16, dat);
      end
    end
    #2 rst_n = 1'b0;
    #1;
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < W; b++) mdl[p][b] = 0;
    check_out(0, "R2");
    check_out(1, "R11/R2");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule